// File: doc/BRIEF.md
# Dual Open-Row Memory Bank Front End

This block sits in front of one single-ported memory bank owned by one small processing element. There is no data cache in that path, so the bank keeps two open-row buffers and uses them to set how long each access takes. Each incoming request is compared against the rows held in the two buffers. When its row is already open, the access finishes after a short fixed latency. When the row is in neither buffer, the access takes a longer fixed latency. During that time the row is copied from the backing array into one of the two buffers.

Requests arrive on a valid/ready port that carries a word address, a write enable and a 32-bit write word. The bank serves one request at a time. Ready stays low from the cycle after a request is accepted until its response cycle. Results come back as a one-cycle response pulse with a 32-bit read word.

Writes go to both the backing array and the buffered row. Because of this, a buffer can be replaced without first writing it back. The backing array is a behavioural register file whose depth is scaled down through parameters.

Top module: `bank_ctrl_top`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, both row buffers are empty and every array word reads as zero. The first access to any row therefore takes the miss latency.
- R2: Only one request is in flight. In the cycle after a request is accepted (req_valid and req_ready both 1 at a rising edge), req_ready is 0. It stays 0 until the response cycle.
- R3: When the request's row (address bits above the column field) is held in either buffer, rsp_valid is 1 exactly HIT_CYC cycles after the accepting edge, and it is 0 before that.
- R4: When the row is in neither buffer, rsp_valid is 1 exactly MISS_CYC cycles after the accepting edge, and it is 0 before that.
- R5: A read returns the most recent value written to that word address. A write returns 0 on rsp_rdata.
- R6: Writes update the backing array as well as the buffer (write-through). Data written into a buffered row survives the eviction of that row.
- R7: On a miss, an empty buffer is filled before an occupied one, with buffer 0 taken first. After two misses to different rows, both rows hit.
- R8: On a miss with both buffers occupied, the buffer whose row was used least recently (by any hit or fill) is replaced.
- R9: rsp_valid is high for a single cycle. req_ready is 1 in that same cycle, so a new request can be accepted at the edge that ends it.
- R10: A request raised and withdrawn while req_ready is 0 is ignored. It produces no response and does not change which rows are buffered.
- R11: The low COL_AW address bits select the word within a row. Two addresses that differ only in those bits share one buffer, so the second of them hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bank idle and able to accept a request |
| req_addr | input | ROW_AW+COL_AW | Word address: row in the upper bits, column in the lower COL_AW bits |
| req_we | input | 1 | 1 for a write, 0 for a read |
| req_wdata | input | 32 | Write word |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read word, or zero for a write |

## Verification
A request is accepted at rising edge e0. Its response appears after edge e0+HIT_CYC for a hit or edge e0+MISS_CYC for a miss, and req_ready is low in every cycle between those two points. The bench keeps a behavioural model of the array contents, the two buffered rows and their use order. From that model it decides ahead of each access whether the access is a hit or a miss. It then samples on every falling edge from the accepting edge onward. It requires rsp_valid and req_ready to stay low until exactly the predicted cycle, and both to be high in that cycle with the predicted read word. The cycle after a response is checked for a low rsp_valid. After a request withdrawn while the bank was busy, the bench checks for silence on rsp_valid over a full miss window.

// File: rtl/bank_pkg.sv
`timescale 1ns/1ps
// Package: shared word type and controller state encoding for the bank front end.
package bank_pkg;
    localparam int WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;
    typedef enum logic {ST_IDLE, ST_BUSY} ctl_state_e;
endpackage

// File: rtl/bank_dram_array.sv
`timescale 1ns/1ps
// bank_dram_array: behavioural backing store, one write word port and one
// full-row read port. Assumes at most one write per cycle; cleared by reset.
module bank_dram_array
    import bank_pkg::*;
#(
    parameter int ROW_AW = 4,
    parameter int COL_AW = 4,
    localparam int ROWS = 1 << ROW_AW,
    localparam int COLS = 1 << COL_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ROW_AW-1:0] wr_row,
    input  logic [COL_AW-1:0] wr_col,
    input  word_t             wr_data,
    input  logic [ROW_AW-1:0] rd_row,
    output word_t             rd_words [COLS]
);
    word_t mem [ROWS][COLS];

    // Storage update: clear on reset, otherwise write one word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                for (int c = 0; c < COLS; c++) begin
                    mem[r][c] <= '0;
                end
            end
        end else if (wr_en) begin
            mem[wr_row][wr_col] <= wr_data;
        end
    end

    // Row read: present every word of the addressed row.
    genvar gc;
    generate
        for (gc = 0; gc < COLS; gc++) begin : g_rd
            assign rd_words[gc] = mem[rd_row][gc];
        end
    endgenerate
endmodule

// File: rtl/bank_row_buffer.sv
`timescale 1ns/1ps
// bank_row_buffer: one open-row buffer holding a full row, its row number
// and a valid flag. A row load and a word write may coincide; the word write
// is applied on top of the loaded row.
module bank_row_buffer
    import bank_pkg::*;
#(
    parameter int ROW_AW = 4,
    parameter int COL_AW = 4,
    localparam int COLS = 1 << COL_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ROW_AW-1:0] load_row,
    input  word_t             load_words [COLS],
    input  logic              wr_en,
    input  logic [COL_AW-1:0] wr_col,
    input  word_t             wr_data,
    input  logic [COL_AW-1:0] rd_col,
    output logic              valid_o,
    output logic [ROW_AW-1:0] row_o,
    output word_t             rd_word_o
);
    word_t             words [COLS];
    logic              valid_q;
    logic [ROW_AW-1:0] row_q;

    // Buffer update: empty on reset, row fill on load, then word overlay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            row_q   <= '0;
            for (int c = 0; c < COLS; c++) begin
                words[c] <= '0;
            end
        end else begin
            if (load_en) begin
                valid_q <= 1'b1;
                row_q   <= load_row;
                for (int c = 0; c < COLS; c++) begin
                    words[c] <= load_words[c];
                end
            end
            if (wr_en) begin
                words[wr_col] <= wr_data;
            end
        end
    end

    // Outputs: state and the selected word.
    assign valid_o   = valid_q;
    assign row_o     = row_q;
    assign rd_word_o = words[rd_col];
endmodule

// File: rtl/bank_way_select.sv
`timescale 1ns/1ps
// bank_way_select: compares a row against both buffers and picks the buffer
// to fill on a miss (empty buffer 0, empty buffer 1, else least recently
// used). One use-order bit is updated when a lookup is committed.
module bank_way_select #(
    parameter int ROW_AW = 4,
    localparam int WAYS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ROW_AW-1:0] lookup_row,
    input  logic [WAYS-1:0]   buf_valid,
    input  logic [ROW_AW-1:0] buf_row [WAYS],
    input  logic              commit,
    output logic              hit,
    output logic              hit_way,
    output logic              fill_way
);
    logic [WAYS-1:0] match;
    logic            lru_q;
    logic            use_way;

    // Per-buffer row comparison.
    genvar gw;
    generate
        for (gw = 0; gw < WAYS; gw++) begin : g_cmp
            assign match[gw] = buf_valid[gw] && (buf_row[gw] == lookup_row);
        end
    endgenerate

    // Hit decode and miss victim choice.
    always_comb begin
        hit     = |match;
        hit_way = match[1];
        if (!buf_valid[0]) begin
            fill_way = 1'b0;
        end else if (!buf_valid[1]) begin
            fill_way = 1'b1;
        end else begin
            fill_way = lru_q;
        end
        use_way = hit ? hit_way : fill_way;
    end

    // Use-order tracking: the buffer not just used becomes the victim.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lru_q <= 1'b0;
        end else if (commit) begin
            lru_q <= ~use_way;
        end
    end
endmodule

// File: rtl/bank_ctrl_top.sv
`timescale 1ns/1ps
// bank_ctrl_top: single-port bank front end with two open-row buffers.
// Accepts one request at a time, decides hit or miss at acceptance, holds
// the bank busy for HIT_CYC or MISS_CYC cycles, then performs the access and
// pulses the response. Assumes 1 <= HIT_CYC <= MISS_CYC.
module bank_ctrl_top
    import bank_pkg::*;
#(
    parameter int ROW_AW   = 4,
    parameter int COL_AW   = 4,
    parameter int HIT_CYC  = 4,
    parameter int MISS_CYC = 8,
    localparam int ADDR_W  = ROW_AW + COL_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata
);
    localparam int COLS  = 1 << COL_AW;
    localparam int WAYS  = 2;
    localparam int CNT_W = $clog2(MISS_CYC + 1);

    ctl_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ROW_AW-1:0] q_row;
    logic [COL_AW-1:0] q_col;
    logic              q_we;
    word_t             q_wdata;
    logic              q_hit;
    logic              q_way;
    logic              rsp_valid_q;
    word_t             rsp_rdata_q;

    logic [ROW_AW-1:0] req_row;
    logic              accept;
    logic              finish;
    logic              lk_hit;
    logic              lk_hit_way;
    logic              lk_fill_way;
    logic [WAYS-1:0]   buf_valid;
    logic [ROW_AW-1:0] buf_row  [WAYS];
    word_t             buf_word [WAYS];
    word_t             arr_words [COLS];

    // Request decode and handshake.
    assign req_row   = req_addr[ADDR_W-1:COL_AW];
    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign finish    = (state_q == ST_BUSY) && (cnt_q == '0);

    bank_way_select #(.ROW_AW(ROW_AW)) way_sel_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .lookup_row (req_row),
        .buf_valid  (buf_valid),
        .buf_row    (buf_row),
        .commit     (accept),
        .hit        (lk_hit),
        .hit_way    (lk_hit_way),
        .fill_way   (lk_fill_way)
    );

    bank_dram_array #(.ROW_AW(ROW_AW), .COL_AW(COL_AW)) array_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (finish && q_we),
        .wr_row   (q_row),
        .wr_col   (q_col),
        .wr_data  (q_wdata),
        .rd_row   (q_row),
        .rd_words (arr_words)
    );

    // Two row buffers, loaded on a miss and written through on every write.
    genvar gw;
    generate
        for (gw = 0; gw < WAYS; gw++) begin : g_buf
            logic sel;
            assign sel = (q_way == gw[0]);
            bank_row_buffer #(.ROW_AW(ROW_AW), .COL_AW(COL_AW)) buf_i (
                .clk        (clk),
                .rst_n      (rst_n),
                .load_en    (finish && !q_hit && sel),
                .load_row   (q_row),
                .load_words (arr_words),
                .wr_en      (finish && q_we && sel),
                .wr_col     (q_col),
                .wr_data    (q_wdata),
                .rd_col     (q_col),
                .valid_o    (buf_valid[gw]),
                .row_o      (buf_row[gw]),
                .rd_word_o  (buf_word[gw])
            );
        end
    endgenerate

    // Sequencer: latch the request and count down its latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            q_row   <= '0;
            q_col   <= '0;
            q_we    <= 1'b0;
            q_wdata <= '0;
            q_hit   <= 1'b0;
            q_way   <= 1'b0;
        end else if (accept) begin
            state_q <= ST_BUSY;
            cnt_q   <= lk_hit ? CNT_W'(HIT_CYC - 1) : CNT_W'(MISS_CYC - 1);
            q_row   <= req_row;
            q_col   <= req_addr[COL_AW-1:0];
            q_we    <= req_we;
            q_wdata <= req_wdata;
            q_hit   <= lk_hit;
            q_way   <= lk_hit ? lk_hit_way : lk_fill_way;
        end else if (finish) begin
            state_q <= ST_IDLE;
        end else if (state_q == ST_BUSY) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Response register: one-cycle pulse with read word or zero for writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            rsp_valid_q <= finish;
            if (finish) begin
                if (q_we) begin
                    rsp_rdata_q <= '0;
                end else if (q_hit) begin
                    rsp_rdata_q <= buf_word[q_way];
                end else begin
                    rsp_rdata_q <= arr_words[q_col];
                end
            end
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_rdata = rsp_rdata_q;
endmodule

// File: rtl/bank_ctrl_chk.sv
`timescale 1ns/1ps
// bank_ctrl_chk: protocol and latency checks on the bank front end ports.
// Keeps its own count of cycles since the last accepted request.
module bank_ctrl_chk #(
    parameter int HIT_CYC  = 4,
    parameter int MISS_CYC = 8
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic rsp_valid
);
    localparam int SW = $clog2(MISS_CYC + 2) + 1;
    localparam logic [SW-1:0] SMAX = '1;

    logic          running;
    logic [SW-1:0] since;

    // Outstanding-request tracker and cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            since   <= '0;
        end else if (req_valid && req_ready) begin
            running <= 1'b1;
            since   <= '0;
        end else begin
            if (rsp_valid) running <= 1'b0;
            if (running && since != SMAX) since <= since + 1'b1;
        end
    end

    // R2: accepted request makes the bank busy on the next cycle.
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2: not ready while a request is outstanding and not yet answered.
    a_r2_no_ready_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !rsp_valid) |-> !req_ready);

    // R3 and R4: response only at the hit or the miss latency.
    a_r4_latency_legal: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (since == SW'(HIT_CYC) || since == SW'(MISS_CYC)));

    // R10: no response without an accepted request.
    a_r10_rsp_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> running);

    // R9: single-cycle response pulse.
    a_r9_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R9: ready in the response cycle.
    a_r9_ready_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);
endmodule

bind bank_ctrl_top bank_ctrl_chk #(.HIT_CYC(HIT_CYC), .MISS_CYC(MISS_CYC)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid)
);

// File: tb/bank_ctrl_top_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural model of array, buffered rows and use order; each
// access is followed cycle by cycle against the predicted latency.
module bank_ctrl_top_tb_top;
    localparam int ROW_AW = 4;
    localparam int COL_AW = 4;
    localparam int HIT    = 4;
    localparam int MISS   = 8;
    localparam int ADDR_W = ROW_AW + COL_AW;
    localparam int COLS   = 1 << COL_AW;
    localparam int NWORDS = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_we = 1'b0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid;
    logic [31:0]       rsp_rdata;

    always #4 clk = ~clk;

    bank_ctrl_top #(.ROW_AW(ROW_AW), .COL_AW(COL_AW), .HIT_CYC(HIT), .MISS_CYC(MISS)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_we    (req_we),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    int          n_checks = 0;
    int          n_fail   = 0;
    bit          done     = 0;
    logic [31:0] ref_mem [NWORDS];
    int          ref_tag [2];
    bit          ref_val [2];
    int          ref_lru;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One access: predict hit/miss from the model, then follow every cycle.
    task automatic access(input int row, input int col, input bit we,
                          input logic [31:0] wd, input string req, input bit noise);
        int          addr;
        int          way;
        int          lat;
        bit          hit;
        bit          early;
        logic [31:0] exp_rd;
        addr = row * COLS + col;
        @(negedge clk);
        check(req_ready && !rsp_valid, "R9", "idle before request (ready,rsp)",
              {30'd0, req_ready, rsp_valid}, 32'h2);
        req_valid = 1'b1;
        req_addr  = ADDR_W'(addr);
        req_we    = we;
        req_wdata = wd;
        hit = 0;
        way = 0;
        for (int w = 0; w < 2; w++) begin
            if (ref_val[w] && ref_tag[w] == row) begin
                hit = 1;
                way = w;
            end
        end
        if (!hit) begin
            if (!ref_val[0]) way = 0;
            else if (!ref_val[1]) way = 1;
            else way = ref_lru;
            ref_val[way] = 1;
            ref_tag[way] = row;
        end
        ref_lru = 1 - way;
        exp_rd = we ? 32'd0 : ref_mem[addr];
        if (we) ref_mem[addr] = wd;
        lat = hit ? HIT : MISS;
        @(posedge clk);
        early = 0;
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            if (i == 0) req_valid = 1'b0;
            if (rsp_valid || req_ready) early = 1;
            if (noise && i == 1) begin
                req_valid = 1'b1;
                req_addr  = ADDR_W'(addr ^ (1 << (ADDR_W - 1)));
                req_we    = 1'b1;
                req_wdata = 32'hDEAD_BEEF;
            end
            if (noise && i == 2) req_valid = 1'b0;
        end
        @(negedge clk);
        check(!early && rsp_valid && req_ready, hit ? {req, " R3 R2"} : {req, " R4 R2"},
              "latency (early,rsp,ready)", {29'd0, early, rsp_valid, req_ready}, 32'h3);
        check(rsp_rdata == exp_rd, {req, " R5"}, "rsp_rdata", rsp_rdata, exp_rd);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        bit quiet;
        for (int a = 0; a < NWORDS; a++) ref_mem[a] = '0;
        ref_val[0] = 0;
        ref_val[1] = 0;
        ref_tag[0] = 0;
        ref_tag[1] = 0;
        ref_lru = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !rsp_valid, "R1", "reset state (ready,rsp)",
              {30'd0, req_ready, rsp_valid}, 32'h2);

        access(3, 5, 0, 0, "R1", 0);                 // cold miss, reads zero
        access(3, 5, 1, 32'hA1A1_0001, "R5", 0);     // write hit
        access(3, 5, 0, 0, "R5", 0);                 // read back
        access(3, 9, 0, 0, "R11", 0);                // other column same row
        access(7, 2, 1, 32'hB2B2_0002, "R7", 0);     // fills empty buffer 1
        access(3, 5, 0, 0, "R7", 0);                 // both rows held
        access(7, 2, 0, 0, "R7", 0);
        access(3, 0, 0, 0, "R8", 0);                 // row 7 now least recent
        access(11, 1, 0, 0, "R8", 0);                // evicts row 7
        access(3, 5, 0, 0, "R8", 0);                 // row 3 kept
        access(7, 2, 0, 0, "R6", 0);                 // written data survived eviction
        access(11, 1, 1, 32'hC3C3_0003, "R8", 0);
        access(0, 0, 0, 0, "R10", 1);                // request raised while busy

        quiet = 1;
        for (int i = 0; i < MISS + 2; i++) begin
            @(negedge clk);
            if (rsp_valid) quiet = 0;
        end
        check(quiet, "R10", "no response to withdrawn request", {31'd0, !quiet}, 32'h0);
        access(0, 0, 0, 0, "R10", 0);                // model unchanged by ignored request
        access(15, 0, 0, 0, "R10", 0);

        seed = 32'h1234_5678;
        for (int n = 0; n < 60; n++) begin
            seed = seed * 1103515245 + 12345;
            access(((seed >>> 8) & 32'h7fff) % 5, (seed >>> 4) & (COLS - 1),
                   seed[20], seed ^ n, "R5", 0);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule